// File: doc/BRIEF.md
# Programmable Frame Event Selector

This block drives one auxiliary strobe on a digital video output port. The strobe reports one raster or frame-buffer event, and a 3-bit configuration picks which one. A raster timing generator supplies the candidate sources as single-cycle strobes or windows, all in the pixel clock domain:

- line start
- field start
- frame start
- tri-level sync
- the window in which the output path may fetch pixel data

The reset mode marks the first displayed frame after a frame-buffer swap. The block drives the fetch window onto the output, but only during a frame that a swap has qualified.

A swap request can arrive at any point in a frame. The block holds it as pending until the next frame start. It then turns it into an active qualifier for exactly that one frame. A new mode value is also held back until the next frame start, so that a receiver never sees a partial frame of one source followed by another. The output is registered, so it lags its selected source by one pixel clock.

Top module: `frame_event_sel`

## Requirements
- R1: While `rst_n` is low, `evt_out` is 0. After reset the active mode is 0 (swap-qualified) and neither the pending nor the active swap flag is set.
- R2: Modes 1 to 5 copy one raw source to `evt_out` one clock later. The codes are 1 line start, 2 field start, 3 frame start, 4 tri-level sync and 5 fetch window.
- R3: Mode 6 holds `evt_out` at 0 and mode 7 holds it at 1, whatever the other inputs do.
- R4: In mode 0, `evt_out` equals the fetch window ANDed with the active swap flag, one clock later.
- R5: A swap pulse that arrives between frame starts sets the pending flag. At the next frame start the flag becomes active for that whole frame, and the active flag clears at the frame start after that unless a new swap is pending. Several pulses within one frame qualify only one frame.
- R6: A swap pulse that arrives in the same cycle as a frame start qualifies the frame after the one that starts in that cycle, not the one that starts.
- R7: A value on `mode_sel` is taken only in a cycle where `frame_start` is high. Changes between frame starts have no effect on `evt_out` until that point.
- R8: In a frame-start cycle, `evt_out` on the next clock is computed from the newly taken mode and the newly transferred swap flag. The first cycle of a frame therefore already belongs to the new frame's settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Requested source code, taken at frame start |
| line_start | input | 1 | Line start strobe |
| field_start | input | 1 | Field start strobe |
| frame_start | input | 1 | Frame start strobe |
| trisync | input | 1 | Tri-level sync strobe |
| fetch_win | input | 1 | Pixel fetch window |
| swap_req | input | 1 | Frame-buffer swap pulse, any time in a frame |
| evt_out | output | 1 | Registered selected event |

## Verification
The bench aims at the cycles where a frame start coincides with something else. A design that let a swap pulse coinciding with a frame start act on the starting frame would raise the output one frame early. One that kept the active flag beyond a single frame would qualify a second, unswapped frame. A mode change is driven mid-frame and must not show until the frame start. If the design used the old mode or flag in the frame-start cycle, the output would be wrong in exactly the first cycle of each frame. Long random runs mix all eight modes with dense and sparse swaps, and a per-cycle model checks every output.

// File: rtl/frame_event_sel.sv
module frame_event_sel #(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              line_start,
  input  logic              field_start,
  input  logic              frame_start,
  input  logic              trisync,
  input  logic              fetch_win,
  input  logic              swap_req,
  output logic              evt_out
);

  localparam logic [MODE_W-1:0] M_SWAP  = MODE_W'(0);
  localparam logic [MODE_W-1:0] M_LINE  = MODE_W'(1);
  localparam logic [MODE_W-1:0] M_FIELD = MODE_W'(2);
  localparam logic [MODE_W-1:0] M_FRAME = MODE_W'(3);
  localparam logic [MODE_W-1:0] M_TRI   = MODE_W'(4);
  localparam logic [MODE_W-1:0] M_WIN   = MODE_W'(5);
  localparam logic [MODE_W-1:0] M_LOW   = MODE_W'(6);
  localparam logic [MODE_W-1:0] M_HIGH  = MODE_W'(7);

  logic [MODE_W-1:0] cur_mode;
  logic              pend_q, act_q;

  // values that govern the cycle: a frame start hands over the new settings
  logic [MODE_W-1:0] eff_mode;
  logic              eff_act;
  logic              pick;

  assign eff_mode = frame_start ? mode_sel : cur_mode;
  assign eff_act  = frame_start ? pend_q   : act_q;

  always_comb begin
    unique case (eff_mode)
      M_SWAP:  pick = fetch_win & eff_act;
      M_LINE:  pick = line_start;
      M_FIELD: pick = field_start;
      M_FRAME: pick = frame_start;
      M_TRI:   pick = trisync;
      M_WIN:   pick = fetch_win;
      M_LOW:   pick = 1'b0;
      M_HIGH:  pick = 1'b1;
      default: pick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_mode <= M_SWAP;
      pend_q   <= 1'b0;
      act_q    <= 1'b0;
      evt_out  <= 1'b0;
    end else begin
      evt_out <= pick;
      if (frame_start) begin
        cur_mode <= mode_sel;
        act_q    <= pend_q;
        pend_q   <= swap_req;
      end else begin
        pend_q   <= pend_q | swap_req;
      end
    end
  end

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cur_mode));

  // R5
  act_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (act_q == $past(pend_q)));

  // R6
  coincident_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && swap_req) |=> pend_q);

  // R4
  win_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && cur_mode == M_SWAP && !fetch_win) |=> !evt_out);

  // R3
  const_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && mode_sel == M_HIGH) |=> evt_out);

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |=> (!evt_out && !act_q && !pend_q));

endmodule

// File: tb/frame_event_sel_tb_top.sv
module frame_event_sel_tb_top;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] mode_sel;
  logic line_start, field_start, frame_start, trisync, fetch_win, swap_req;
  logic evt_out;

  always #2.5 clk = ~clk;

  frame_event_sel dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .line_start(line_start), .field_start(field_start),
    .frame_start(frame_start), .trisync(trisync),
    .fetch_win(fetch_win), .swap_req(swap_req), .evt_out(evt_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [2:0] m_mode;
  logic m_pend, m_act;

  function automatic logic ref_out(input logic [2:0] m, input logic act,
                                   input logic ln, input logic fd, input logic fr,
                                   input logic ts, input logic win);
    case (m)
      3'd0: return win & act;
      3'd1: return ln;
      3'd2: return fd;
      3'd3: return fr;
      3'd4: return ts;
      3'd5: return win;
      3'd6: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] m);
    if (m == 3'd0) return "R4";
    if (m >= 3'd6) return "R3";
    return "R2";
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: evt_out=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  // drive at negedge, advance one edge, check at the following negedge
  task automatic step(input string req, input logic [2:0] ms, input logic ln,
                      input logic fd, input logic fr, input logic ts,
                      input logic win, input logic sw);
    logic [2:0] em;
    logic ea, exp;
    mode_sel = ms; line_start = ln; field_start = fd; frame_start = fr;
    trisync = ts; fetch_win = win; swap_req = sw;
    em  = fr ? ms : m_mode;
    ea  = fr ? m_pend : m_act;
    exp = ref_out(em, ea, ln, fd, fr, ts, win);
    if (fr) begin m_mode = ms; m_act = m_pend; m_pend = sw; end
    else m_pend = m_pend | sw;
    @(posedge clk);
    @(negedge clk);
    check(req == "" ? tag_of(em) : req, evt_out, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    mode_sel = 3'd7; line_start = 1; field_start = 1; frame_start = 1;
    trisync = 1; fetch_win = 1; swap_req = 1;
    repeat (4) @(negedge clk);
    check("R1", evt_out, 1'b0);
    rst_n = 1'b1;
    m_mode = 3'd0; m_pend = 1'b0; m_act = 1'b0;

    // R1: reset default is swap-qualified mode with no swap seen
    step("R1", 3'd0, 0, 0, 0, 0, 1, 0);
    step("R1", 3'd7, 0, 0, 0, 0, 1, 0);
    // R5: mid-frame swaps (two pulses) do not affect the current frame
    step("R5", 3'd0, 0, 0, 0, 0, 1, 1);
    step("R5", 3'd0, 0, 0, 0, 0, 1, 0);
    step("R5", 3'd0, 0, 0, 0, 0, 1, 1);
    // R8: qualified frame begins in the frame-start cycle itself
    step("R8", 3'd0, 0, 0, 1, 0, 1, 0);
    step("R4", 3'd0, 0, 0, 0, 0, 0, 0);
    step("R4", 3'd0, 0, 0, 0, 0, 1, 0);
    // R5: the frame after is not qualified
    step("R5", 3'd0, 0, 0, 1, 0, 1, 0);
    step("R5", 3'd0, 0, 0, 0, 0, 1, 0);
    // R6: swap together with a frame start waits one more frame
    step("R6", 3'd0, 0, 0, 1, 0, 1, 1);
    step("R6", 3'd0, 0, 0, 0, 0, 1, 0);
    step("R6", 3'd0, 0, 0, 1, 0, 1, 0);
    step("R6", 3'd0, 0, 0, 0, 0, 1, 0);
    // R7: mode change mid-frame is ignored until the frame start
    step("R7", 3'd3, 1, 1, 0, 1, 0, 0);
    step("R7", 3'd7, 0, 0, 0, 0, 0, 0);
    step("R8", 3'd3, 0, 0, 1, 0, 0, 0);
    step("R2", 3'd0, 1, 1, 0, 1, 1, 0);
    // R3: constant modes
    step("R3", 3'd7, 0, 0, 1, 0, 0, 0);
    step("R3", 3'd0, 0, 0, 0, 0, 0, 0);
    step("R3", 3'd6, 1, 1, 1, 1, 1, 1);
    step("R3", 3'd6, 1, 1, 0, 1, 1, 0);
    // R2: each raw source alone
    for (int m = 1; m <= 5; m++) begin
      step("R2", 3'(m), 0, 0, 1, 0, 0, 0);
      step("R2", 3'(m), m == 1, m == 2, 0, m == 4, m == 5, 0);
      step("R2", 3'(m), m != 1, m != 2, 0, m != 4, m != 5, 0);
    end

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      logic [2:0] ms;
      ms = (i % 400 < 200) ? 3'd0 : 3'($urandom % 8);
      step("", ms, ($urandom % 6) == 0, ($urandom % 40) == 0,
           ($urandom % 23) == 0, ($urandom % 9) == 0, ($urandom % 3) != 0,
           ($urandom % ((i % 1000 < 500) ? 5 : 60)) == 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule